// File: doc/BRIEF.md
# Periodic Millisecond Interrupt Timer

This block raises a periodic interrupt request whose period is programmed in whole milliseconds. A slow reference clock, presented to the block as a one-cycle strobe per reference cycle in the system clock domain, drives a fractional accumulator. The accumulator turns 32768 reference cycles into exactly 1000 millisecond ticks. A counter, gated by a count-enable bit, counts those ticks. When it reaches the programmed period, it sets a sticky event flag.

Software sees two words. The period word reads back what was last written. The status word holds the count-enable, the interrupt-enable and the event flag at fixed bit positions. Software clears the flag by writing the status word back with the flag bit at 1. The interrupt output is the flag gated by the interrupt-enable. To get a rate of F Hz, software writes 1000/F to the period word for F from 1 to 1000. It then sets both enable bits together to start the timer, and clears both to stop it.

Top module: `msirq_timer`

## Requirements
- R1: After reset, the status word, the period word and the interrupt output are all zero.
- R2: A write through the period strobe sets the period word, and the period word reads back exactly the value written from the following cycle.
- R3: A write through the control strobe loads count-enable from data bit 15 and interrupt-enable from data bit 14. The status word shows them at bits 15 and 14, and every status bit other than 15, 14 and 13 reads 0.
- R4: On each reference strobe the accumulator adds 1000 modulo 32768. A millisecond tick is produced on exactly those strobes where the sum wraps, giving 1000 ticks per 32768 strobes. No tick is produced in a cycle without a strobe.
- R5: With count-enable high and a period P > 0, the counter advances once per tick. On the tick where the count plus one reaches P, it reloads to zero and sets the event flag (status bit 13) in the same cycle.
- R6: While count-enable is low, the counter holds at zero and the flag is never set, so after re-enabling, the first flag comes P ticks later.
- R7: A period of zero is treated as disabled: the counter holds at zero and no flag is set.
- R8: A control write with data bit 13 at 1 clears the flag, and a control write with bit 13 at 0 leaves it unchanged. When a flag set and a clear fall in the same cycle, the set wins.
- R9: The interrupt output is high exactly when the flag and the interrupt-enable are both 1.
- R10: If the period is lowered below the current count, the next tick reloads the counter and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock cycle |
| wr_ctrl | input | 1 | Write strobe for the status/control word |
| wr_period | input | 1 | Write strobe for the period word |
| wr_data | input | DATA_W | Write data for either strobe |
| status_rd | output | DATA_W | Status word: bit 15 count-enable, bit 14 interrupt-enable, bit 13 event flag |
| period_rd | output | PERIOD_W | Period word in milliseconds |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks the following on every cycle:
- the period readback after a write;
- that a flag rise always coincides with a millisecond tick while counting is enabled with a non-zero period;
- that the flag is sticky until cleared, that a clear takes effect, and that the interrupt needs both flag and enable.

The exact cycle of every flag rise can only be shown by the bench scenarios. This depends on the accumulator phase, on the period, on gapped strobes, on re-enabling and on period changes during a count. The bench's scoreboard predicts these cycles from the accumulator and counter rules. The scenarios also show that the timer stays silent with counting off, with a zero period and with no strobes.

// File: rtl/msirq_pkg.sv
package msirq_pkg;
   // Bit positions in the status word; software decodes these.
   localparam int CE_POS   = 15;
   localparam int IE_POS   = 14;
   localparam int FLAG_POS = 13;
endpackage

// File: rtl/msirq_tick_gen.sv
module msirq_tick_gen #(
   parameter int REF_HZ  = 32768,
   parameter int TICK_HZ = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   output logic ms_tick
);
   localparam int ACC_W = $clog2(REF_HZ) + 1;

   generate
      if (REF_HZ % TICK_HZ == 0) begin : g_div
         // Integer ratio: a plain modulo divider.
         localparam logic [ACC_W-1:0] LAST = ACC_W'(REF_HZ / TICK_HZ - 1);
         logic [ACC_W-1:0] div_q;
         assign ms_tick = ref_tick && (div_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_q <= '0;
            else if (ms_tick)  div_q <= '0;
            else if (ref_tick) div_q <= div_q + 1'b1;
         end
      end else begin : g_acc
         // Fractional ratio: add TICK_HZ, wrap at REF_HZ.
         localparam logic [ACC_W-1:0] STEP   = ACC_W'(TICK_HZ);
         localparam logic [ACC_W-1:0] THRESH = ACC_W'(REF_HZ - TICK_HZ);
         logic [ACC_W-1:0] acc_q;
         assign ms_tick = ref_tick && (acc_q >= THRESH);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (ms_tick)  acc_q <= acc_q - THRESH;
            else if (ref_tick) acc_q <= acc_q + STEP;
         end
      end
   endgenerate
endmodule

// File: rtl/msirq_period_count.sv
module msirq_period_count #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                count_en,
   input  logic                ms_tick,
   input  logic [PERIOD_W-1:0] period,
   output logic                flag_set
);
   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W:0]   cnt_inc;
   logic                run;
   logic                at_end;

   always_comb begin
      cnt_inc  = {1'b0, cnt_q} + 1'b1;
      at_end   = cnt_inc >= {1'b0, period};
      run      = count_en && (period != '0);
      flag_set = run && ms_tick && at_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (ms_tick) cnt_q <= at_end ? '0 : cnt_inc[PERIOD_W-1:0];
   end
endmodule

// File: rtl/msirq_ctrl_regs.sv
module msirq_ctrl_regs #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctrl,
   input  logic                wr_period,
   input  logic                d_ce,
   input  logic                d_ie,
   input  logic                d_clr,
   input  logic [PERIOD_W-1:0] d_period,
   input  logic                flag_set,
   output logic                ce,
   output logic                ie,
   output logic                flag,
   output logic [PERIOD_W-1:0] period
);
   logic clr;
   assign clr = wr_ctrl && d_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce     <= 1'b0;
         ie     <= 1'b0;
         flag   <= 1'b0;
         period <= '0;
      end else begin
         if (wr_ctrl) begin
            ce <= d_ce;
            ie <= d_ie;
         end
         if (wr_period) period <= d_period;
         // a new event outranks a simultaneous clear
         flag <= flag_set | (flag & ~clr);
      end
   end
endmodule

// File: rtl/msirq_timer.sv
module msirq_timer #(
   parameter int REF_HZ   = 32768,
   parameter int TICK_HZ  = 1000,
   parameter int DATA_W   = 16,
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_tick,
   input  logic                wr_ctrl,
   input  logic                wr_period,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   status_rd,
   output logic [PERIOD_W-1:0] period_rd,
   output logic                irq
);
   import msirq_pkg::*;

   if (DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must hold the status bits");
   end
   if (PERIOD_W > DATA_W) begin : g_bad_period_w
      $error("PERIOD_W must not exceed DATA_W");
   end
   if (TICK_HZ < 1 || TICK_HZ >= REF_HZ) begin : g_bad_ratio
      $error("TICK_HZ must be below REF_HZ");
   end

   logic ms_tick;
   logic flag_set;
   logic ce, ie, flag;
   logic [PERIOD_W-1:0] period;

   msirq_tick_gen #(.REF_HZ(REF_HZ), .TICK_HZ(TICK_HZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ms_tick(ms_tick)
   );

   msirq_period_count #(.PERIOD_W(PERIOD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .count_en(ce), .ms_tick(ms_tick),
      .period(period), .flag_set(flag_set)
   );

   msirq_ctrl_regs #(.PERIOD_W(PERIOD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_period(wr_period),
      .d_ce(wr_data[CE_POS]), .d_ie(wr_data[IE_POS]), .d_clr(wr_data[FLAG_POS]),
      .d_period(wr_data[PERIOD_W-1:0]), .flag_set(flag_set),
      .ce(ce), .ie(ie), .flag(flag), .period(period)
   );

   always_comb begin
      status_rd           = '0;
      status_rd[CE_POS]   = ce;
      status_rd[IE_POS]   = ie;
      status_rd[FLAG_POS] = flag;
      period_rd           = period;
      irq                 = flag & ie;
   end
endmodule

// File: rtl/msirq_timer_chk.sv
module msirq_timer_chk #(
   parameter int DATA_W   = 16,
   parameter int PERIOD_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_ctrl,
   input logic                wr_period,
   input logic [DATA_W-1:0]   wr_data,
   input logic [DATA_W-1:0]   status_rd,
   input logic [PERIOD_W-1:0] period_rd,
   input logic                irq,
   input logic                ms_tick,
   input logic                flag_set
);
   // R2
   period_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_period |=> period_rd == $past(wr_data[PERIOD_W-1:0]));
   // R5
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_rd[13]) |-> $past(ms_tick));
   // R6
   rise_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_rd[13]) |-> $past(status_rd[15]));
   // R7
   rise_needs_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_rd[13]) |-> $past(period_rd) != '0);
   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd[13] && !(wr_ctrl && wr_data[13])) |=> status_rd[13]);
   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wr_data[13] && !flag_set) |=> !status_rd[13]);
   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set |=> status_rd[13]);
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status_rd[14] && status_rd[13]));
   // R3
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd & ~(DATA_W'(16'hE000))) == '0);
endmodule

bind msirq_timer msirq_timer_chk #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_period(wr_period),
   .wr_data(wr_data), .status_rd(status_rd), .period_rd(period_rd),
   .irq(irq), .ms_tick(ms_tick), .flag_set(flag_set)
);

// File: tb/msirq_timer_bench.sv
module msirq_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        wr_ctrl = 1'b0;
   logic        wr_period = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] status_rd;
   logic [15:0] period_rd;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   int cyc = 0;
   int exp_q[$];

   always #4 clk = ~clk;

   msirq_timer u_msirq_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_ctrl(wr_ctrl),
      .wr_period(wr_period), .wr_data(wr_data), .status_rd(status_rd),
      .period_rd(period_rd), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference model of the requirements; predicts each flag rise.
   int m_acc, m_cnt, m_per;
   bit m_ce, m_ie, m_flag;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; m_cnt = 0; m_per = 0; m_ce = 0; m_ie = 0; m_flag = 0; cyc = 0;
      end else begin
         bit tk, st, clr;
         cyc++;
         tk = ref_tick && (m_acc + 1000 >= 32768);                  // R4
         st = m_ce && tk && (m_per != 0) && (m_cnt + 1 >= m_per);   // R5 R7 R10
         clr = wr_ctrl && wr_data[13];
         if (st && !m_flag) exp_q.push_back(cyc);
         if (ref_tick) m_acc = tk ? m_acc + 1000 - 32768 : m_acc + 1000;
         if (!m_ce || m_per == 0) m_cnt = 0;                        // R6
         else if (tk) m_cnt = st ? 0 : m_cnt + 1;
         m_flag = st || (m_flag && !clr);                           // R8
         if (wr_ctrl) begin m_ce = wr_data[15]; m_ie = wr_data[14]; end
         if (wr_period) m_per = wr_data;
      end
   end

   // Monitor: every observed flag rise must match the next predicted cycle.
   bit prev_flag = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (status_rd[13] && !prev_flag) begin
            if (exp_q.size() == 0) chk("R5 unexpected flag rise at cycle", cyc, -1);
            else chk("R5 flag rise cycle", cyc, exp_q.pop_front());
         end
         prev_flag = status_rd[13];
      end
   end

   task automatic wr_ctl(input logic [15:0] d);
      @(negedge clk); wr_ctrl = 1'b1; wr_data = d;
      @(negedge clk); wr_ctrl = 1'b0; wr_data = '0;
   endtask

   task automatic wr_per(input logic [15:0] d);
      @(negedge clk); wr_period = 1'b1; wr_data = d;
      @(negedge clk); wr_period = 1'b0; wr_data = '0;
   endtask

   // gap=1 drives a strobe every cycle, gap=0 drives none
   task automatic run(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ref_tick = (gap != 0) && (i % gap == 0);
      end
      @(negedge clk); ref_tick = 1'b0;
   endtask

   task automatic wait_flag(input int limit, output bit seen);
      seen = 1'b0;
      ref_tick = 1'b1;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         seen = status_rd[13];
      end
      ref_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   initial begin
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", status_rd, 0);
      chk("R1 period after reset", period_rd, 0);
      chk("R1 irq after reset", irq, 0);

      wr_per(16'h1234);
      chk("R2 period readback", period_rd, 16'h1234);
      wr_per(16'd3);
      chk("R2 period readback 3", period_rd, 3);

      wr_ctl(16'h8FFF);
      chk("R3 ce only, spare bits zero", status_rd, 16'h8000);

      wait_flag(400, seen);
      chk("R5 flag raised after period", status_rd[13], 1);
      chk("R9 irq low with ie clear", irq, 0);

      wr_ctl(16'hC000);
      chk("R8 write of 0 at bit 13 keeps flag", status_rd, 16'hE000);
      chk("R9 irq high with flag and ie", irq, 1);

      wr_ctl(16'hE000);
      chk("R8 w1c clears flag", status_rd, 16'hC000);
      chk("R9 irq low after clear", irq, 0);

      run(3000, 3);   // gapped strobes, scoreboard checks each rise (R4)
      wr_ctl(16'hE000);

      wr_ctl(16'h4000);
      chk("R3 ie only", status_rd, 16'h4000);
      run(3000, 1);
      chk("R6 no flag with count disabled", status_rd[13], 0);

      wr_per(16'd0);
      wr_ctl(16'hC000);
      run(3000, 1);
      chk("R7 no flag with zero period", status_rd[13], 0);

      wr_per(16'd1);
      run(3000, 0);
      chk("R4 no tick without strobes", status_rd[13], 0);
      wait_flag(40, seen);
      chk("R4 tick within 33 strobes", seen, 1);
      wr_ctl(16'hE000);

      wr_per(16'd20);
      run(330, 1);
      wr_ctl(16'hE000);
      wr_per(16'd2);
      wait_flag(40, seen);
      chk("R10 lowered period reloads on next tick", seen, 1);
      wr_ctl(16'hE000);

      wr_ctl(16'h2000);
      run(200, 1);
      wr_per(16'd4);
      wr_ctl(16'hC000);   // R6 restart counts from zero, timed by scoreboard
      run(2000, 1);
      wr_ctl(16'h0000);
      repeat (4) @(negedge clk);
      chk("R5 all predicted rises observed", exp_q.size(), 0);
      finish_up();
   end
endmodule